// File: doc/BRIEF.md
# Windowed Watchdog Timer with Configuration Locks

This block is a watchdog that software must service before a programmable down-counter reaches zero. It is configured and serviced through a small word-wide slave register port. The counter loads a 32-bit time-out value and counts one step per clock while enabled. When the count runs out, the block either asks for a system reset at once or first raises an interrupt and asks for reset only if the interrupt is still pending on the next expiry. An optional window makes a service that comes too early as fatal as one that comes too late. The counter can be held while the chip is in debug or in stop mode, each under its own control bit.

Configuration can be frozen by a soft lock, which a two-word key sequence releases, or by a hard lock, which only reset releases. Every access is screened. An access is rejected if it is not a full aligned word, if the requesting master is masked off, if the address is reserved, if it writes a read-only register, or if it writes a stray value to the service register while the watchdog runs. A rejected access produces either a one-cycle bus error or a reset request, chosen by a control bit. The reset request is sticky until `rst_n`. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `wdt_window_lock`

## Requirements
- R1: After reset, CTRL (offset 0x00) reads 0x0000FF00, STATUS reads 0, and `irq`, `rst_req` and `bus_err` are low. The CTRL bits are: 0 enable, 1 debug freeze, 2 stop halt, 3 interrupt-first, 4 window enable, 5 reset-on-invalid, 6 soft lock, 7 hard lock; bits 15:8 are a permit mask with one bit per master id.
- R2: Register map: STATUS 0x04 (bit 0 is the interrupt flag), TIMEOUT 0x08, WINDOW 0x0C, SERVICE 0x10, COUNT 0x14 (read-only); 0x18 and 0x1C are reserved. While disabled, COUNT holds the TIMEOUT value. Once enabled it starts at TIMEOUT and drops by one per clock. A COUNT read returns the value held just before the access edge.
- R3: With interrupt-first clear, an enabled counter with TIMEOUT N raises `rst_req` N+1 clocks after the enabling write. `rst_req` then stays high until `rst_n`.
- R4: With interrupt-first set, the first expiry sets the STATUS flag (`irq`) and reloads the counter. An expiry while the flag is set raises `rst_req`. Writing 1 to STATUS bit 0 clears the flag.
- R5: Writing 0x0000A602 and then 0x0000B480 to SERVICE reloads the counter from TIMEOUT. A service that completes in the same cycle as an expiry wins: no expiry event occurs.
- R6: With window enable set, a service completing while COUNT >= WINDOW raises `rst_req`; below WINDOW it reloads normally.
- R7: While `dbg_mode` is high and debug freeze is set, the counter holds; with debug freeze clear it keeps counting.
- R8: While `stop_mode` is high and stop halt is set, the counter holds, and it resumes from the held value with no reload.
- R9: An access is invalid if `bus_size` is not 2'b10 (word), if address bits 1:0 are not zero, if the master's permit bit is clear, if the offset is reserved, or if it writes COUNT. An invalid read returns 0 and an invalid write changes nothing.
- R10: The response to an invalid access comes one cycle after the access. With reset-on-invalid clear it is a one-cycle `bus_err`; with it set it is `rst_req` and no `bus_err`. A SERVICE write that is not the next key in a sequence is invalid while enabled and is ignored while disabled.
- R11: While the soft lock is set, writes to CTRL, TIMEOUT and WINDOW are invalid and have no effect. Writing 0x0000C520 and then 0x0000D928 to SERVICE clears the soft lock.
- R12: The hard lock blocks the same writes as the soft lock. The unlock keys do not clear it; only reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the block |
| bus_size | input | 2 | Access size code, 2'b10 = word |
| bus_master | input | MID_W (3) | Requesting master id |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle error response, registered |
| dbg_mode | input | 1 | Chip is in debug mode |
| stop_mode | input | 1 | Chip is in stop mode |
| irq | output | 1 | Interrupt flag after the first expiry |
| rst_req | output | 1 | Sticky system reset request |

## Verification
Two events can land on the same clock edge: the closing service key and the counter reaching expiry. The bench enables a four-count time-out in interrupt-first mode and times the two keys so that the second is written in the cycle where COUNT is already zero. It then judges the result by reading COUNT back as the full TIMEOUT value with `irq` still low. A second case closes a service while the count is at or above WINDOW; there, a service write that would otherwise reload instead raises the reset request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic hard_lock;
    logic soft_lock;
    logic ria;
    logic win_en;
    logic irq_first;
    logic stop_halt;
    logic dbg_freeze;
    logic en;
  } wdt_ctrl_t;

  localparam logic [2:0] RG_CTRL = 3'd0;
  localparam logic [2:0] RG_STAT = 3'd1;
  localparam logic [2:0] RG_TO   = 3'd2;
  localparam logic [2:0] RG_WIN  = 3'd3;
  localparam logic [2:0] RG_SVC  = 3'd4;
  localparam logic [2:0] RG_CNT  = 3'd5;

  localparam logic [1:0] SIZE_WORD = 2'b10;

  localparam logic [31:0] KEY_SVC_1 = 32'h0000_A602;
  localparam logic [31:0] KEY_SVC_2 = 32'h0000_B480;
  localparam logic [31:0] KEY_UNL_1 = 32'h0000_C520;
  localparam logic [31:0] KEY_UNL_2 = 32'h0000_D928;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SVC  = 2'd1,
    SEQ_UNL  = 2'd2
  } wdt_seq_e;

endpackage

// File: rtl/wdt_access.sv
module wdt_access
  import wdt_pkg::*;
#(
  parameter int MID_W = 3
) (
  input  logic                  sel,
  input  logic                  wr,
  input  logic [4:0]            addr,
  input  logic [1:0]            size,
  input  logic [MID_W-1:0]      master,
  input  logic [(1<<MID_W)-1:0] permit,
  input  logic                  locked,
  output logic [2:0]            idx,
  output logic                  acc_bad,
  output logic                  rd_ok,
  output logic                  we_ctrl,
  output logic                  we_stat,
  output logic                  we_to,
  output logic                  we_win,
  output logic                  we_svc
);

  logic fmt_bad;
  logic map_bad;
  logic perm_bad;
  logic ro_bad;
  logic good;

  always_comb begin
    idx      = addr[4:2];
    fmt_bad  = (size != SIZE_WORD) || (addr[1:0] != 2'b00);
    map_bad  = (idx > RG_CNT);
    perm_bad = !permit[master];
    ro_bad   = wr && ((idx == RG_CNT) ||
               (locked && ((idx == RG_CTRL) || (idx == RG_TO) || (idx == RG_WIN))));
    acc_bad  = sel && (fmt_bad || map_bad || perm_bad || ro_bad);
    good     = sel && !(fmt_bad || map_bad || perm_bad || ro_bad);
    rd_ok    = good && !wr;
    we_ctrl  = good && wr && (idx == RG_CTRL);
    we_stat  = good && wr && (idx == RG_STAT);
    we_to    = good && wr && (idx == RG_TO);
    we_win   = good && wr && (idx == RG_WIN);
    we_svc   = good && wr && (idx == RG_SVC);
  end

endmodule

// File: rtl/wdt_svc_seq.sv
module wdt_svc_seq
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic [31:0] wdata,
  output logic        svc_done,
  output logic        unl_done,
  output logic        bad_key
);

  wdt_seq_e seq_q;
  wdt_seq_e seq_n;

  always_comb begin
    seq_n    = seq_q;
    svc_done = 1'b0;
    unl_done = 1'b0;
    bad_key  = 1'b0;
    if (wr_stb) begin
      seq_n = SEQ_IDLE;
      if (wdata == KEY_SVC_1) begin
        seq_n = SEQ_SVC;
      end else if (wdata == KEY_UNL_1) begin
        seq_n = SEQ_UNL;
      end else if ((wdata == KEY_SVC_2) && (seq_q == SEQ_SVC)) begin
        svc_done = 1'b1;
      end else if ((wdata == KEY_UNL_2) && (seq_q == SEQ_UNL)) begin
        unl_done = 1'b1;
      end else begin
        bad_key = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SEQ_IDLE;
    end else if (wr_stb) begin
      seq_q <= seq_n;
    end
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          run,
  input  logic          reload,
  input  logic [CW-1:0] load_val,
  input  logic          irq_first,
  input  logic          flag,
  output logic [CW-1:0] cnt,
  output logic          tmo_irq,
  output logic          tmo_rst
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic          cnt_ce;
  logic          expire;

  always_comb begin
    expire  = en && run && !reload && (cnt_q == '0);
    tmo_irq = expire && irq_first && !flag;
    tmo_rst = expire && !(irq_first && !flag);
    cnt_ce  = !en || reload || run;
    if (!en || reload || expire) begin
      cnt_n = load_val;
    end else begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_n;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/wdt_window_lock.sv
module wdt_window_lock
  import wdt_pkg::*;
#(
  parameter int          CW      = 32,
  parameter int          MID_W   = 3,
  parameter logic [31:0] TO_INIT = 32'h0000_1000,
  parameter logic [31:0] WIN_INIT = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [4:0]       bus_addr,
  input  logic [1:0]       bus_size,
  input  logic [MID_W-1:0] bus_master,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_err,
  input  logic             dbg_mode,
  input  logic             stop_mode,
  output logic             irq,
  output logic             rst_req
);

  localparam int NM = 1 << MID_W;

  logic [1:0]    rsync_q;
  logic          rst_ni;

  wdt_ctrl_t     ctrl_q, ctrl_n;
  logic [NM-1:0] permit_q, permit_n;
  logic [CW-1:0] to_q, to_n;
  logic [CW-1:0] win_q, win_n;
  logic          flag_q, flag_n;
  logic          rreq_q, rreq_n;
  logic          err_q, err_n;
  logic [31:0]   rdata_q, rdata_n;

  logic [2:0]    idx;
  logic          acc_bad, rd_ok;
  logic          we_ctrl, we_stat, we_to, we_win, we_svc;
  logic          svc_done, unl_done, bad_key;
  logic [CW-1:0] cnt;
  logic          tmo_irq, tmo_rst;
  logic          locked, invalid, in_win, reload, win_viol, run;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_ni = rsync_q[1];

  assign locked = ctrl_q.soft_lock || ctrl_q.hard_lock;

  wdt_access #(.MID_W(MID_W)) u_access (
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .size    (bus_size),
    .master  (bus_master),
    .permit  (permit_q),
    .locked  (locked),
    .idx     (idx),
    .acc_bad (acc_bad),
    .rd_ok   (rd_ok),
    .we_ctrl (we_ctrl),
    .we_stat (we_stat),
    .we_to   (we_to),
    .we_win  (we_win),
    .we_svc  (we_svc)
  );

  wdt_svc_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wr_stb   (we_svc),
    .wdata    (bus_wdata),
    .svc_done (svc_done),
    .unl_done (unl_done),
    .bad_key  (bad_key)
  );

  wdt_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_ni),
    .en        (ctrl_q.en),
    .run       (run),
    .reload    (reload),
    .load_val  (to_q),
    .irq_first (ctrl_q.irq_first),
    .flag      (flag_q),
    .cnt       (cnt),
    .tmo_irq   (tmo_irq),
    .tmo_rst   (tmo_rst)
  );

  always_comb begin
    run      = !(dbg_mode && ctrl_q.dbg_freeze) && !(stop_mode && ctrl_q.stop_halt);
    in_win   = !ctrl_q.win_en || (cnt < win_q);
    reload   = svc_done && in_win;
    win_viol = svc_done && !in_win && ctrl_q.en;
    invalid  = acc_bad || (bad_key && ctrl_q.en);
  end

  always_comb begin
    ctrl_n   = ctrl_q;
    permit_n = permit_q;
    if (we_ctrl) begin
      ctrl_n   = wdt_ctrl_t'(bus_wdata[7:0]);
      permit_n = bus_wdata[8 +: NM];
    end
    if (unl_done) begin
      ctrl_n.soft_lock = 1'b0;
    end
  end

  always_comb begin
    to_n   = we_to  ? bus_wdata[CW-1:0] : to_q;
    win_n  = we_win ? bus_wdata[CW-1:0] : win_q;
    flag_n = flag_q;
    if (we_stat && bus_wdata[0]) begin
      flag_n = 1'b0;
    end
    if (tmo_irq) begin
      flag_n = 1'b1;
    end
    rreq_n = rreq_q || tmo_rst || win_viol || (invalid && ctrl_q.ria);
    err_n  = invalid && !ctrl_q.ria;
  end

  always_comb begin
    rdata_n = '0;
    if (rd_ok) begin
      case (idx)
        RG_CTRL: begin
          rdata_n[7:0]     = ctrl_q;
          rdata_n[8 +: NM] = permit_q;
        end
        RG_STAT: rdata_n[0]      = flag_q;
        RG_TO:   rdata_n[CW-1:0] = to_q;
        RG_WIN:  rdata_n[CW-1:0] = win_q;
        RG_CNT:  rdata_n[CW-1:0] = cnt;
        default: rdata_n         = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      permit_q <= '1;
    end else if (we_ctrl || unl_done) begin
      ctrl_q   <= ctrl_n;
      permit_q <= permit_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q  <= TO_INIT[CW-1:0];
      win_q <= WIN_INIT[CW-1:0];
    end else if (we_to || we_win) begin
      to_q  <= to_n;
      win_q <= win_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      rreq_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      flag_q  <= flag_n;
      rreq_q  <= rreq_n;
      err_q   <= err_n;
      rdata_q <= rdata_n;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign irq       = flag_q;
  assign rst_req   = rreq_q;

endmodule

// File: rtl/wdt_window_lock_chk.sv
module wdt_window_lock_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          dbg_freeze,
  input logic          stop_halt,
  input logic          dbg_mode,
  input logic          stop_mode,
  input logic          soft_lock,
  input logic          hard_lock,
  input logic          reload,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] to_val,
  input logic          rst_req
);

  AST_LOCK_FREEZES_TO: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_lock || hard_lock) |=> $stable(to_val)); // R11

  AST_HARD_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hard_lock |=> hard_lock); // R12

  AST_RST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req); // R3

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dbg_mode && dbg_freeze && !reload) |=> $stable(cnt)); // R7

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop_mode && stop_halt && !reload) |=> $stable(cnt)); // R8

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(dbg_mode && dbg_freeze) && !(stop_mode && stop_halt) && !reload && (cnt != '0))
      |=> (cnt == CW'($past(cnt) - 1'b1))); // R2

endmodule

bind wdt_window_lock wdt_window_lock_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_ni),
  .en         (ctrl_q.en),
  .dbg_freeze (ctrl_q.dbg_freeze),
  .stop_halt  (ctrl_q.stop_halt),
  .dbg_mode   (dbg_mode),
  .stop_mode  (stop_mode),
  .soft_lock  (ctrl_q.soft_lock),
  .hard_lock  (ctrl_q.hard_lock),
  .reload     (reload),
  .cnt        (cnt),
  .to_val     (to_q),
  .rst_req    (rst_req)
);

// File: tb/wdt_window_lock_bench.sv
`timescale 1ns/1ps
module wdt_window_lock_bench;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [2:0]  bus_master;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        dbg_mode;
  logic        stop_mode;
  logic        irq;
  logic        rst_req;

  int nvec;
  int nfail;

  wdt_window_lock u_wdt_window_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_master (bus_master),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .dbg_mode   (dbg_mode),
    .stop_mode  (stop_mode),
    .irq        (irq),
    .rst_req    (rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [1:0]  size;
    logic [2:0]  mst;
    logic [31:0] wdata;
    logic        exp_err;
    logic [31:0] exp_rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 5'h00, 2'b10, 3'd0, 32'h0,         1'b0, 32'h0000FF00, 4'd1},  // R1 ctrl reset
    '{1'b0, 5'h04, 2'b10, 3'd0, 32'h0,         1'b0, 32'h0,        4'd1},  // R1 status reset
    '{1'b1, 5'h08, 2'b10, 3'd0, 32'h40,        1'b0, 32'h0,        4'd9},  // R9 write timeout
    '{1'b0, 5'h08, 2'b10, 3'd0, 32'h0,         1'b0, 32'h40,       4'd9},  // R9
    '{1'b1, 5'h0C, 2'b10, 3'd0, 32'h10,        1'b0, 32'h0,        4'd9},  // R9 write window
    '{1'b0, 5'h0C, 2'b10, 3'd0, 32'h0,         1'b0, 32'h10,       4'd9},  // R9
    '{1'b0, 5'h08, 2'b01, 3'd0, 32'h0,         1'b1, 32'h0,        4'd9},  // R9 halfword
    '{1'b0, 5'h18, 2'b10, 3'd0, 32'h0,         1'b1, 32'h0,        4'd9},  // R9 reserved
    '{1'b1, 5'h14, 2'b10, 3'd0, 32'h5,         1'b1, 32'h0,        4'd9},  // R9 write count
    '{1'b0, 5'h0A, 2'b10, 3'd0, 32'h0,         1'b1, 32'h0,        4'd9},  // R9 misaligned
    '{1'b1, 5'h00, 2'b10, 3'd0, 32'h0000FD00,  1'b0, 32'h0,        4'd9},  // R9 bar master 1
    '{1'b0, 5'h00, 2'b10, 3'd1, 32'h0,         1'b1, 32'h0,        4'd9},  // R9 barred master
    '{1'b0, 5'h00, 2'b10, 3'd0, 32'h0,         1'b0, 32'h0000FD00, 4'd9},  // R9
    '{1'b1, 5'h00, 2'b10, 3'd0, 32'h0000FD40,  1'b0, 32'h0,        4'd11}, // R11 soft lock on
    '{1'b1, 5'h08, 2'b10, 3'd0, 32'h99,        1'b1, 32'h0,        4'd11}, // R11 blocked
    '{1'b0, 5'h08, 2'b10, 3'd0, 32'h0,         1'b0, 32'h40,       4'd11}, // R11 unchanged
    '{1'b1, 5'h10, 2'b10, 3'd0, 32'h0000C520,  1'b0, 32'h0,        4'd11}, // R11 key 1
    '{1'b1, 5'h10, 2'b10, 3'd0, 32'h0000D928,  1'b0, 32'h0,        4'd11}, // R11 key 2
    '{1'b0, 5'h00, 2'b10, 3'd0, 32'h0,         1'b0, 32'h0000FD00, 4'd11}, // R11 unlocked
    '{1'b1, 5'h08, 2'b10, 3'd0, 32'h22,        1'b0, 32'h0,        4'd11}, // R11 writable
    '{1'b0, 5'h08, 2'b10, 3'd0, 32'h0,         1'b0, 32'h22,       4'd11}, // R11
    '{1'b1, 5'h10, 2'b10, 3'd0, 32'h1234,      1'b0, 32'h0,        4'd10}, // R10 stray key, disabled
    '{1'b0, 5'h08, 2'b00, 3'd0, 32'h0,         1'b1, 32'h0,        4'd9},  // R9 byte size
    '{1'b0, 5'h14, 2'b10, 3'd0, 32'h0,         1'b0, 32'h22,       4'd2}   // R2 count mirrors timeout
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // caller is at a falling edge; returns at the next falling edge
  task automatic bus(input logic wr, input logic [4:0] addr, input logic [1:0] size,
                     input logic [2:0] mst, input logic [31:0] wdata,
                     output logic err, output logic [31:0] rd);
    bus_sel    = 1'b1;
    bus_wr     = wr;
    bus_addr   = addr;
    bus_size   = size;
    bus_master = mst;
    bus_wdata  = wdata;
    @(posedge clk);
    @(negedge clk);
    err     = bus_err;
    rd      = bus_rdata;
    bus_sel = 1'b0;
    bus_wr  = 1'b0;
  endtask

  task automatic wr_reg(input logic [4:0] addr, input logic [31:0] data, output logic err);
    logic [31:0] rd;
    bus(1'b1, addr, 2'b10, 3'd0, data, err, rd);
  endtask

  task automatic rd_reg(input logic [4:0] addr, output logic [31:0] rd);
    logic err;
    bus(1'b0, addr, 2'b10, 3'd0, 32'h0, err, rd);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n      = 1'b0;
    bus_sel    = 1'b0;
    bus_wr     = 1'b0;
    bus_addr   = '0;
    bus_size   = 2'b10;
    bus_master = '0;
    bus_wdata  = '0;
    dbg_mode   = 1'b0;
    stop_mode  = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    #750000;
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic        e;
    logic [31:0] r;
    nvec  = 0;
    nfail = 0;
    @(negedge clk);
    do_reset();

    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 rst_req after reset", {31'b0, rst_req}, 32'h0);
    check("R1 bus_err after reset", {31'b0, bus_err}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      bus(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].mst, VECS[i].wdata, e, r);
      check($sformatf("R%0d vec%0d err", VECS[i].req, i), {31'b0, e}, {31'b0, VECS[i].exp_err});
      check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), r, VECS[i].exp_rd);
    end

    // R3: reset on first expiry
    do_reset();
    wr_reg(5'h08, 32'd5, e);
    wr_reg(5'h00, 32'h0000FF01, e);
    idle(5);
    check("R3 no reset before expiry", {31'b0, rst_req}, 32'h0);
    idle(1);
    check("R3 reset at expiry", {31'b0, rst_req}, 32'h1);
    check("R3 no irq in reset mode", {31'b0, irq}, 32'h0);
    idle(4);
    check("R3 reset request sticky", {31'b0, rst_req}, 32'h1);

    // R4: interrupt first, then reset
    do_reset();
    wr_reg(5'h08, 32'd5, e);
    wr_reg(5'h00, 32'h0000FF09, e);
    idle(5);
    check("R4 irq low before expiry", {31'b0, irq}, 32'h0);
    idle(1);
    check("R4 irq at first expiry", {31'b0, irq}, 32'h1);
    check("R4 no reset at first expiry", {31'b0, rst_req}, 32'h0);
    idle(5);
    check("R4 no reset before second expiry", {31'b0, rst_req}, 32'h0);
    idle(1);
    check("R4 reset at second expiry", {31'b0, rst_req}, 32'h1);

    // R4: write-one-to-clear
    do_reset();
    wr_reg(5'h08, 32'd5, e);
    wr_reg(5'h00, 32'h0000FF09, e);
    idle(6);
    wr_reg(5'h04, 32'h1, e);
    check("R4 flag cleared by write one", {31'b0, irq}, 32'h0);
    rd_reg(5'h04, r);
    check("R4 status reads zero", r, 32'h0);

    // R5: service reload
    do_reset();
    wr_reg(5'h08, 32'd8, e);
    wr_reg(5'h00, 32'h0000FF01, e);
    idle(4);
    wr_reg(5'h10, 32'h0000A602, e);
    wr_reg(5'h10, 32'h0000B480, e);
    rd_reg(5'h14, r);
    check("R5 count reloaded", r, 32'd8);
    check("R5 no reset after service", {31'b0, rst_req}, 32'h0);

    // R5: service closes in the expiry cycle
    do_reset();
    wr_reg(5'h08, 32'd4, e);
    wr_reg(5'h00, 32'h0000FF09, e);
    idle(3);
    wr_reg(5'h10, 32'h0000A602, e);
    wr_reg(5'h10, 32'h0000B480, e);
    check("R5 service beats expiry irq", {31'b0, irq}, 32'h0);
    rd_reg(5'h14, r);
    check("R5 service beats expiry count", r, 32'd4);

    // R6: early service in window mode
    do_reset();
    wr_reg(5'h08, 32'd20, e);
    wr_reg(5'h0C, 32'd5, e);
    wr_reg(5'h00, 32'h0000FF11, e);
    wr_reg(5'h10, 32'h0000A602, e);
    wr_reg(5'h10, 32'h0000B480, e);
    check("R6 early service resets", {31'b0, rst_req}, 32'h1);

    // R6: service inside window
    do_reset();
    wr_reg(5'h08, 32'd20, e);
    wr_reg(5'h0C, 32'd5, e);
    wr_reg(5'h00, 32'h0000FF11, e);
    idle(16);
    wr_reg(5'h10, 32'h0000A602, e);
    wr_reg(5'h10, 32'h0000B480, e);
    check("R6 in-window service no reset", {31'b0, rst_req}, 32'h0);
    rd_reg(5'h14, r);
    check("R6 in-window reload", r, 32'd20);

    // R10: stray service value while enabled
    do_reset();
    wr_reg(5'h08, 32'd50, e);
    wr_reg(5'h00, 32'h0000FF01, e);
    wr_reg(5'h10, 32'h00001111, e);
    check("R10 stray key bus error", {31'b0, e}, 32'h1);
    check("R10 stray key no reset", {31'b0, rst_req}, 32'h0);
    do_reset();
    wr_reg(5'h08, 32'd50, e);
    wr_reg(5'h00, 32'h0000FF21, e);
    wr_reg(5'h10, 32'h00001111, e);
    check("R10 reset-on-invalid no bus error", {31'b0, e}, 32'h0);
    check("R10 reset-on-invalid raises reset", {31'b0, rst_req}, 32'h1);

    // R7: debug freeze
    do_reset();
    wr_reg(5'h08, 32'd10, e);
    dbg_mode = 1'b1;
    wr_reg(5'h00, 32'h0000FF03, e);
    idle(20);
    rd_reg(5'h14, r);
    check("R7 frozen in debug", r, 32'd10);
    do_reset();
    wr_reg(5'h08, 32'd10, e);
    dbg_mode = 1'b1;
    wr_reg(5'h00, 32'h0000FF01, e);
    idle(3);
    rd_reg(5'h14, r);
    check("R7 runs in debug without freeze", r, 32'd7);

    // R8: stop halt and resume
    do_reset();
    wr_reg(5'h08, 32'd10, e);
    wr_reg(5'h00, 32'h0000FF05, e);
    idle(3);
    stop_mode = 1'b1;
    idle(10);
    stop_mode = 1'b0;
    rd_reg(5'h14, r);
    check("R8 resume from held value", r, 32'd7);

    // R12: hard lock survives unlock keys
    do_reset();
    wr_reg(5'h00, 32'h0000FF80, e);
    wr_reg(5'h10, 32'h0000C520, e);
    wr_reg(5'h10, 32'h0000D928, e);
    wr_reg(5'h08, 32'h77, e);
    check("R12 timeout write blocked", {31'b0, e}, 32'h1);
    rd_reg(5'h00, r);
    check("R12 hard lock still set", r, 32'h0000FF80);
    rd_reg(5'h08, r);
    check("R12 timeout unchanged", r, 32'h0000_1000);

    summary();
    $finish;
  end

endmodule